// File: doc/BRIEF.md
# Shared Pin Function Controller

This block owns one general-purpose pin that the chip can use either as a status output or as a control input. A 16-bit configuration word selects the behaviour. When output is enabled, the pin carries one status flag picked by a code: ADC data ready, NVM busy, a channel busy flag, or the window-comparator-1 result.

When input is enabled, the pin is passed through a two-flop synchronizer and, if chosen, a glitch filter that accepts a new level only after it has held for four clocks. Falling and rising edges, or the low level, are then turned into action outputs for the rest of the chip. Global actions are fault dump, protect, clear, reset, NVM write-protect and register-map lock. Per-channel actions apply to three DAC channels picked by an enable mask: power down/up, load-DAC, function-generator stop/start and margin low/high. Per-channel and fault-dump actions are one-cycle pulses. Protect, clear, reset, write-protect and lock are held levels.

While the lock level is set, the block also gates register write requests. Only writes aimed at the unlock field or the reset field get through.

Top module: `gpio_func_ctrl`

## Requirements
- R1: `pin_oe` equals `cfg[13]`. While `cfg[13]` is 1, `pin_out` follows, in the same cycle, the flag picked by `cfg[12:9]`: 0000 ADC ready, 0001 NVM busy, 0100 channel-2 busy, 0110 channel-0 busy, 0111 channel-1 busy, 1011 window comparator 1. Any other code, or `cfg[13]`=0, drives `pin_out` to 0.
- R2: With `cfg[0]`=0, every action output, pulse or level, is 0 from the clock after the change on.
- R3: The channel mask `cfg[8:5]` maps bit 0 to channel 2, bit 2 to channel 0 and bit 3 to channel 1, and bit 1 is ignored. Per-channel output vectors are indexed by channel number.
- R4: Input code `cfg[4:1]`=0010 gives a one-cycle `fault_dump_p` pulse on a pin falling edge, and a rising edge does nothing. Without the filter, the pulse is high in the third clock after the pin changes.
- R5: Code 0101 sets `protect_lvl` on a falling edge. A high pin does not clear it. It drops only when the code or input enable is removed.
- R6: Code 0111 holds `clear_lvl` high while the synchronized pin is low, with the same three-clock latency.
- R7: Code 0100 pulses `pwr_dn_p` on a falling edge and `pwr_up_p` on a rising edge, for the masked channels only.
- R8: Code 1001 pulses `fg_stop_p` on a falling edge and `fg_start_p` on a rising edge. Code 1010 pulses `mrg_lo_p` on a falling edge and `mrg_hi_p` on a rising edge. Both apply to the masked channels.
- R9: Code 1000 pulses `ldac_p` for the masked channels on a falling edge only.
- R10: Code 1011 sets `reset_lvl` on a falling edge and clears it on a rising edge.
- R11: Code 1100 clears `nvm_wp_lvl` on a falling edge and sets it on a rising edge. Code 1101 clears `lock_lvl` on a falling edge and sets it on a rising edge. Each of these levels, and `reset_lvl`, reads 0 in the cycle after its code is deselected.
- R12: `wr_grant` equals `wr_req` when unlocked. While `lock_lvl` is 1, it is granted only if `wr_unlock_fld` or `wr_reset_fld` is 1.
- R13: With `cfg[15]`=1, a pin level must persist for four clocks before it is accepted, so an action appears in the seventh clock after the pin change. A two-clock glitch gives no action. `cfg[14]` has no effect.
- R14: Input codes other than those listed produce no action output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg | input | 16 | Configuration word |
| sts_adc_rdy | input | 1 | ADC data-ready flag |
| sts_nvm_busy | input | 1 | NVM busy flag |
| sts_ch_busy | input | 3 | Per-channel busy flags, index = channel |
| sts_win_cmp1 | input | 1 | Window comparator 1 result |
| pin_in | input | 1 | Pin level from the pad |
| pin_out | output | 1 | Pin drive value |
| pin_oe | output | 1 | Pin output enable |
| fault_dump_p | output | 1 | Fault-dump pulse |
| protect_lvl | output | 1 | Protect level |
| clear_lvl | output | 1 | Clear level |
| reset_lvl | output | 1 | Reset level |
| nvm_wp_lvl | output | 1 | NVM write-protect level |
| lock_lvl | output | 1 | Register-map lock level |
| pwr_dn_p | output | 3 | Per-channel power-down pulse |
| pwr_up_p | output | 3 | Per-channel power-up pulse |
| ldac_p | output | 3 | Per-channel load-DAC pulse |
| fg_stop_p | output | 3 | Per-channel function-generator stop pulse |
| fg_start_p | output | 3 | Per-channel function-generator start pulse |
| mrg_lo_p | output | 3 | Per-channel margin-low pulse |
| mrg_hi_p | output | 3 | Per-channel margin-high pulse |
| wr_req | input | 1 | Register write request |
| wr_unlock_fld | input | 1 | Write targets the unlock field |
| wr_reset_fld | input | 1 | Write targets the reset field |
| wr_grant | output | 1 | Write allowed |

## Verification
The output mux and the write gate are combinational, so the bench samples them one time unit after it changes inputs. Pin edges are driven on the falling clock edge. Without the filter, an action is due right after the third following rising edge, and the bench samples both the second edge (expecting nothing) and the third. One edge later it checks that a pulse has ended. With the filter on, the same pair of samples is taken at the sixth and seventh edges. Removing a code or the input enable is checked one edge later.

// File: rtl/gpio_func_ctrl.sv
module gpio_func_ctrl #(
  parameter int GF_LEN = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] cfg,
  input  logic        sts_adc_rdy,
  input  logic        sts_nvm_busy,
  input  logic [2:0]  sts_ch_busy,
  input  logic        sts_win_cmp1,
  input  logic        pin_in,
  output logic        pin_out,
  output logic        pin_oe,
  output logic        fault_dump_p,
  output logic        protect_lvl,
  output logic        clear_lvl,
  output logic        reset_lvl,
  output logic        nvm_wp_lvl,
  output logic        lock_lvl,
  output logic [2:0]  pwr_dn_p,
  output logic [2:0]  pwr_up_p,
  output logic [2:0]  ldac_p,
  output logic [2:0]  fg_stop_p,
  output logic [2:0]  fg_start_p,
  output logic [2:0]  mrg_lo_p,
  output logic [2:0]  mrg_hi_p,
  input  logic        wr_req,
  input  logic        wr_unlock_fld,
  input  logic        wr_reset_fld,
  output logic        wr_grant
);
  localparam int CW = (GF_LEN > 1) ? $clog2(GF_LEN) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(GF_LEN - 1);

  localparam logic [3:0] IC_FDUMP = 4'b0010;
  localparam logic [3:0] IC_PWR   = 4'b0100;
  localparam logic [3:0] IC_PROT  = 4'b0101;
  localparam logic [3:0] IC_CLR   = 4'b0111;
  localparam logic [3:0] IC_LDAC  = 4'b1000;
  localparam logic [3:0] IC_FG    = 4'b1001;
  localparam logic [3:0] IC_MRG   = 4'b1010;
  localparam logic [3:0] IC_RST   = 4'b1011;
  localparam logic [3:0] IC_WP    = 4'b1100;
  localparam logic [3:0] IC_LOCK  = 4'b1101;

  logic       in_en, gf_en;
  logic [3:0] icode, ocode;
  logic [2:0] chm;

  assign in_en = cfg[0];
  assign gf_en = cfg[15];
  assign icode = cfg[4:1];
  assign ocode = cfg[12:9];
  assign chm   = {cfg[5], cfg[8], cfg[7]};

  logic flag;
  always_comb begin
    case (ocode)
      4'b0000: flag = sts_adc_rdy;
      4'b0001: flag = sts_nvm_busy;
      4'b0100: flag = sts_ch_busy[2];
      4'b0110: flag = sts_ch_busy[0];
      4'b0111: flag = sts_ch_busy[1];
      4'b1011: flag = sts_win_cmp1;
      default: flag = 1'b0;
    endcase
  end
  assign pin_oe  = cfg[13];
  assign pin_out = cfg[13] & flag;

  logic          s1, s2, filt_q, prev_q;
  logic [CW-1:0] cnt;
  logic          lvl, fall, rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1     <= 1'b1;
      s2     <= 1'b1;
      filt_q <= 1'b1;
      prev_q <= 1'b1;
      cnt    <= '0;
    end else begin
      s1     <= pin_in;
      s2     <= s1;
      prev_q <= lvl;
      if (!gf_en || s2 == filt_q) begin
        filt_q <= s2;
        cnt    <= '0;
      end else if (cnt == CNT_LAST) begin
        filt_q <= s2;
        cnt    <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign lvl  = gf_en ? filt_q : s2;
  assign fall = prev_q & ~lvl;
  assign rise = ~prev_q & lvl;

  logic sel_fd, sel_pwr, sel_prot, sel_clr, sel_ldac, sel_fg, sel_mrg;
  logic sel_rst, sel_wp, sel_lock;
  assign sel_fd   = in_en && icode == IC_FDUMP;
  assign sel_pwr  = in_en && icode == IC_PWR;
  assign sel_prot = in_en && icode == IC_PROT;
  assign sel_clr  = in_en && icode == IC_CLR;
  assign sel_ldac = in_en && icode == IC_LDAC;
  assign sel_fg   = in_en && icode == IC_FG;
  assign sel_mrg  = in_en && icode == IC_MRG;
  assign sel_rst  = in_en && icode == IC_RST;
  assign sel_wp   = in_en && icode == IC_WP;
  assign sel_lock = in_en && icode == IC_LOCK;

  logic [2:0] m_fall, m_rise;
  assign m_fall = fall ? chm : 3'b000;
  assign m_rise = rise ? chm : 3'b000;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_dump_p <= 1'b0;
      clear_lvl    <= 1'b0;
      pwr_dn_p     <= '0;
      pwr_up_p     <= '0;
      ldac_p       <= '0;
      fg_stop_p    <= '0;
      fg_start_p   <= '0;
      mrg_lo_p     <= '0;
      mrg_hi_p     <= '0;
    end else begin
      fault_dump_p <= sel_fd & fall;
      clear_lvl    <= sel_clr & ~lvl;
      pwr_dn_p     <= sel_pwr  ? m_fall : 3'b000;
      pwr_up_p     <= sel_pwr  ? m_rise : 3'b000;
      ldac_p       <= sel_ldac ? m_fall : 3'b000;
      fg_stop_p    <= sel_fg   ? m_fall : 3'b000;
      fg_start_p   <= sel_fg   ? m_rise : 3'b000;
      mrg_lo_p     <= sel_mrg  ? m_fall : 3'b000;
      mrg_hi_p     <= sel_mrg  ? m_rise : 3'b000;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      protect_lvl <= 1'b0;
      reset_lvl   <= 1'b0;
      nvm_wp_lvl  <= 1'b0;
      lock_lvl    <= 1'b0;
    end else begin
      if (!sel_prot)  protect_lvl <= 1'b0;
      else if (fall)  protect_lvl <= 1'b1;

      if (!sel_rst)   reset_lvl <= 1'b0;
      else if (fall)  reset_lvl <= 1'b1;
      else if (rise)  reset_lvl <= 1'b0;

      if (!sel_wp)    nvm_wp_lvl <= 1'b0;
      else if (fall)  nvm_wp_lvl <= 1'b0;
      else if (rise)  nvm_wp_lvl <= 1'b1;

      if (!sel_lock)  lock_lvl <= 1'b0;
      else if (fall)  lock_lvl <= 1'b0;
      else if (rise)  lock_lvl <= 1'b1;
    end
  end

  assign wr_grant = wr_req & (~lock_lvl | wr_unlock_fld | wr_reset_fld);
endmodule

// File: rtl/gpio_func_ctrl_chk.sv
module gpio_func_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] cfg,
  input logic        pin_out,
  input logic        pin_oe,
  input logic        fault_dump_p,
  input logic        protect_lvl,
  input logic        clear_lvl,
  input logic        reset_lvl,
  input logic        nvm_wp_lvl,
  input logic        lock_lvl,
  input logic [2:0]  pwr_dn_p,
  input logic [2:0]  pwr_up_p,
  input logic [2:0]  ldac_p,
  input logic [2:0]  fg_stop_p,
  input logic [2:0]  fg_start_p,
  input logic [2:0]  mrg_lo_p,
  input logic [2:0]  mrg_hi_p,
  input logic        wr_req,
  input logic        wr_unlock_fld,
  input logic        wr_reset_fld,
  input logic        wr_grant
);
  logic [20:0] pulses;
  assign pulses = {pwr_dn_p, pwr_up_p, ldac_p, fg_stop_p, fg_start_p, mrg_lo_p, mrg_hi_p};

  // R1
  out_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg[13] |-> (!pin_oe && !pin_out));

  // R2
  in_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg[0] |=> (pulses == '0 && !fault_dump_p && !protect_lvl && !clear_lvl
                 && !reset_lvl && !nvm_wp_lvl && !lock_lvl));

  // R4
  fdump_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_dump_p |=> !fault_dump_p);

  // R7
  pwr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_dn_p & pwr_up_p) == 3'b000);

  // R8
  fg_mrg_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((fg_stop_p & fg_start_p) | (mrg_lo_p & mrg_hi_p)) == 3'b000);

  // R12
  lock_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_lvl && !wr_unlock_fld && !wr_reset_fld) |-> !wr_grant);

  // R12
  open_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_lvl |-> (wr_grant == wr_req));

  // R14
  bad_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg[0] && (cfg[4:1] == 4'b0000 || cfg[4:1] == 4'b1111)) |=>
      (pulses == '0 && !fault_dump_p && !clear_lvl));
endmodule

bind gpio_func_ctrl gpio_func_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg(cfg), .pin_out(pin_out), .pin_oe(pin_oe),
  .fault_dump_p(fault_dump_p), .protect_lvl(protect_lvl), .clear_lvl(clear_lvl),
  .reset_lvl(reset_lvl), .nvm_wp_lvl(nvm_wp_lvl), .lock_lvl(lock_lvl),
  .pwr_dn_p(pwr_dn_p), .pwr_up_p(pwr_up_p), .ldac_p(ldac_p),
  .fg_stop_p(fg_stop_p), .fg_start_p(fg_start_p), .mrg_lo_p(mrg_lo_p),
  .mrg_hi_p(mrg_hi_p), .wr_req(wr_req), .wr_unlock_fld(wr_unlock_fld),
  .wr_reset_fld(wr_reset_fld), .wr_grant(wr_grant)
);

// File: tb/gpio_func_ctrl_bench.sv
`timescale 1ns/1ps
module gpio_func_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cfg = '0;
  logic        sts_adc_rdy = 0, sts_nvm_busy = 0, sts_win_cmp1 = 0;
  logic [2:0]  sts_ch_busy = '0;
  logic        pin_in = 1'b1;
  logic        wr_req = 0, wr_unlock_fld = 0, wr_reset_fld = 0;
  logic        pin_out, pin_oe, fault_dump_p, protect_lvl, clear_lvl;
  logic        reset_lvl, nvm_wp_lvl, lock_lvl, wr_grant;
  logic [2:0]  pwr_dn_p, pwr_up_p, ldac_p, fg_stop_p, fg_start_p, mrg_lo_p, mrg_hi_p;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  gpio_func_ctrl u_gpio_func_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg(cfg), .sts_adc_rdy(sts_adc_rdy),
    .sts_nvm_busy(sts_nvm_busy), .sts_ch_busy(sts_ch_busy), .sts_win_cmp1(sts_win_cmp1),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .fault_dump_p(fault_dump_p),
    .protect_lvl(protect_lvl), .clear_lvl(clear_lvl), .reset_lvl(reset_lvl),
    .nvm_wp_lvl(nvm_wp_lvl), .lock_lvl(lock_lvl), .pwr_dn_p(pwr_dn_p),
    .pwr_up_p(pwr_up_p), .ldac_p(ldac_p), .fg_stop_p(fg_stop_p),
    .fg_start_p(fg_start_p), .mrg_lo_p(mrg_lo_p), .mrg_hi_p(mrg_hi_p),
    .wr_req(wr_req), .wr_unlock_fld(wr_unlock_fld), .wr_reset_fld(wr_reset_fld),
    .wr_grant(wr_grant)
  );

  logic [31:0] any_act;
  assign any_act = {fault_dump_p, protect_lvl, clear_lvl, reset_lvl, nvm_wp_lvl, lock_lvl,
                    pwr_dn_p, pwr_up_p, ldac_p, fg_stop_p, fg_start_p, mrg_lo_p, mrg_hi_p};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic setpin(input logic v);
    @(negedge clk);
    pin_in = v;
  endtask

  task automatic setcfg(input logic gf, input logic oe, input logic [3:0] oc,
                        input logic [3:0] msk, input logic [3:0] ic, input logic ie);
    @(negedge clk);
    cfg = {gf, 1'b0, oe, oc, msk, ic, ie};
    step(4);
  endtask

  task automatic settle();
    setpin(1'b1);
    step(10);
  endtask

  task automatic t_reset_state();
    chk("R2 reset actions", any_act, 0);
    chk("R1 reset oe", {31'b0, pin_oe}, 0);
    chk("R12 reset grant", {31'b0, wr_grant}, 0);
  endtask

  task automatic t_output();
    setcfg(0, 1, 4'b1011, 0, 0, 0);
    sts_win_cmp1 = 1; #1;
    chk("R1 win cmp", {pin_oe, pin_out}, 2'b11);
    cfg[12:9] = 4'b0110; sts_ch_busy = 3'b001; #1;
    chk("R1 ch0 busy", {31'b0, pin_out}, 1);
    cfg[12:9] = 4'b0111; #1;
    chk("R1 ch1 busy low", {31'b0, pin_out}, 0);
    cfg[12:9] = 4'b0100; sts_ch_busy = 3'b100; #1;
    chk("R1 ch2 busy", {31'b0, pin_out}, 1);
    cfg[12:9] = 4'b0000; sts_adc_rdy = 1; #1;
    chk("R1 adc ready", {31'b0, pin_out}, 1);
    cfg[12:9] = 4'b0001; sts_nvm_busy = 1; #1;
    chk("R1 nvm busy", {31'b0, pin_out}, 1);
    sts_ch_busy = 3'b111; cfg[12:9] = 4'b0010; #1;
    chk("R1 unused code", {31'b0, pin_out}, 0);
    cfg[13] = 0; cfg[12:9] = 4'b1011; #1;
    chk("R1 output off", {pin_oe, pin_out}, 0);
  endtask

  task automatic t_fault();
    setcfg(0, 0, 0, 0, 4'b0010, 1);
    setpin(0); step(2);
    chk("R4 not yet", {31'b0, fault_dump_p}, 0);
    step(1);
    chk("R4 fault pulse", {31'b0, fault_dump_p}, 1);
    step(1);
    chk("R4 single cycle", {31'b0, fault_dump_p}, 0);
    setpin(1); step(3);
    chk("R4 rise ignored", any_act, 0);
    step(3);
    cfg[14] = 1;
    setpin(0); step(3);
    chk("R13 bit14 no effect", {31'b0, fault_dump_p}, 1);
    cfg[14] = 0;
    settle();
  endtask

  task automatic t_protect();
    setcfg(0, 0, 0, 0, 4'b0101, 1);
    setpin(0); step(3);
    chk("R5 protect set", {31'b0, protect_lvl}, 1);
    setpin(1); step(6);
    chk("R5 protect held", {31'b0, protect_lvl}, 1);
    @(negedge clk); cfg[0] = 0; step(1);
    chk("R2 input off clears", any_act, 0);
    settle();
  endtask

  task automatic t_clear();
    setcfg(0, 0, 0, 0, 4'b0111, 1);
    setpin(0); step(2);
    chk("R6 clear not yet", {31'b0, clear_lvl}, 0);
    step(1);
    chk("R6 clear asserted", {31'b0, clear_lvl}, 1);
    step(5);
    chk("R6 clear held", {31'b0, clear_lvl}, 1);
    setpin(1); step(3);
    chk("R6 clear released", {31'b0, clear_lvl}, 0);
    settle();
  endtask

  task automatic t_power();
    setcfg(0, 0, 0, 4'b1001, 4'b0100, 1);
    setpin(0); step(3);
    chk("R7 R3 pwr down ch2 ch1", {pwr_dn_p, pwr_up_p}, 6'b110_000);
    setpin(1); step(3);
    chk("R7 R3 pwr up ch2 ch1", {pwr_dn_p, pwr_up_p}, 6'b000_110);
    setcfg(0, 0, 0, 4'b0110, 4'b0100, 1);
    setpin(0); step(3);
    chk("R3 bit1 ignored ch0", {pwr_dn_p, pwr_up_p}, 6'b001_000);
    settle();
  endtask

  task automatic t_fg_mrg();
    setcfg(0, 0, 0, 4'b1111, 4'b1001, 1);
    setpin(0); step(3);
    chk("R8 fg stop", {fg_stop_p, fg_start_p}, 6'b111_000);
    setpin(1); step(3);
    chk("R8 fg start", {fg_stop_p, fg_start_p}, 6'b000_111);
    setcfg(0, 0, 0, 4'b0100, 4'b1010, 1);
    setpin(0); step(3);
    chk("R8 margin low ch0", {mrg_lo_p, mrg_hi_p}, 6'b001_000);
    setpin(1); step(3);
    chk("R8 margin high ch0", {mrg_lo_p, mrg_hi_p}, 6'b000_001);
    settle();
  endtask

  task automatic t_ldac();
    setcfg(0, 0, 0, 4'b1000, 4'b1000, 1);
    setpin(0); step(3);
    chk("R9 ldac ch1", {29'b0, ldac_p}, 3'b010);
    step(1);
    chk("R9 ldac ends", {29'b0, ldac_p}, 0);
    setpin(1); step(3);
    chk("R9 rise no ldac", any_act, 0);
    settle();
  endtask

  task automatic t_rst();
    setcfg(0, 0, 0, 0, 4'b1011, 1);
    setpin(0); step(3);
    chk("R10 reset set", {31'b0, reset_lvl}, 1);
    step(4);
    chk("R10 reset held", {31'b0, reset_lvl}, 1);
    setpin(1); step(3);
    chk("R10 reset released", {31'b0, reset_lvl}, 0);
    settle();
  endtask

  task automatic t_wp_lock();
    setcfg(0, 0, 0, 0, 4'b1100, 1);
    setpin(0); step(3);
    chk("R11 wp allow", {31'b0, nvm_wp_lvl}, 0);
    setpin(1); step(3);
    chk("R11 wp block", {31'b0, nvm_wp_lvl}, 1);
    setcfg(0, 0, 0, 0, 4'b1101, 1);
    chk("R11 wp drops when deselected", {31'b0, nvm_wp_lvl}, 0);
    setpin(0); step(3);
    chk("R11 unlocked", {31'b0, lock_lvl}, 0);
    wr_req = 1; #1;
    chk("R12 grant open", {31'b0, wr_grant}, 1);
    setpin(1); step(3);
    chk("R11 locked", {31'b0, lock_lvl}, 1);
    chk("R12 plain write blocked", {31'b0, wr_grant}, 0);
    wr_unlock_fld = 1; #1;
    chk("R12 unlock field passes", {31'b0, wr_grant}, 1);
    wr_unlock_fld = 0; wr_reset_fld = 1; #1;
    chk("R12 reset field passes", {31'b0, wr_grant}, 1);
    wr_reset_fld = 0; wr_req = 0;
    @(negedge clk); cfg[4:1] = 4'b0000; step(1);
    chk("R11 lock drops when deselected", {31'b0, lock_lvl}, 0);
    settle();
  endtask

  task automatic t_invalid();
    int hits;
    hits = 0;
    setcfg(0, 0, 0, 4'b1111, 4'b1111, 1);
    setpin(0);
    for (int i = 0; i < 6; i++) begin step(1); if (any_act != 0) hits++; end
    setpin(1);
    for (int i = 0; i < 6; i++) begin step(1); if (any_act != 0) hits++; end
    chk("R14 unknown code silent", hits, 0);
    hits = 0;
    setcfg(0, 0, 0, 4'b1111, 4'b0010, 0);
    setpin(0);
    for (int i = 0; i < 6; i++) begin step(1); if (any_act != 0) hits++; end
    chk("R2 input disabled silent", hits, 0);
    settle();
  endtask

  task automatic t_filter();
    int hits;
    hits = 0;
    setcfg(1, 0, 0, 0, 4'b0010, 1);
    setpin(0); setpin(0); setpin(1);
    for (int i = 0; i < 12; i++) begin step(1); if (fault_dump_p) hits++; end
    chk("R13 glitch rejected", hits, 0);
    setpin(0); step(6);
    chk("R13 filtered not yet", {31'b0, fault_dump_p}, 0);
    step(1);
    chk("R13 filtered pulse", {31'b0, fault_dump_p}, 1);
    step(1);
    chk("R13 filtered single", {31'b0, fault_dump_p}, 0);
    settle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    step(3);
    t_reset_state();
    @(negedge clk); rst_n = 1'b1;
    step(2);
    t_output();
    t_fault();
    t_protect();
    t_clear();
    t_power();
    t_fg_mrg();
    t_ldac();
    t_rst();
    t_wp_lock();
    t_invalid();
    t_filter();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule